// File: doc/BRIEF.md
# Palette Controller Host Register Interface

This block is the register front end that a host processor uses to program a video color-palette controller. The host drives an asynchronous bus with active-low read and write strobes, a register select and an 8-bit data bus. Both strobes are brought into the pixel clock domain through synchronizer flops. Each transfer takes effect once, on the synchronized trailing (rising) edge of its strobe. Eight direct register slots are decoded. They cover a write-side and a read-side palette address, a color holding register through which red, green and blue bytes stream into a 256-entry RGB palette, a pixel read mask, and an index/data pair. The index/data pair gives indirect access to a small bank of extended registers, one of which is a configuration register.

On the pixel side the block looks up the palette entry addressed by the pixel index ANDed with the read mask, one clock after the index is presented. It then realigns the color for 6-bit or 8-bit data. The width comes either from a dual-function mode input or, once the configuration register claims that input for its alternate use, from a configuration bit.

Top module: `pal_host_if`

## Requirements
- R1: After reset the pixel read mask reads 0xFF, both palette addresses, the index and every extended register read 0x00, and all palette entries are 0x000000.
- R2: The register select bits [2:0] decode as: 000 write-side palette address, 001 color holding register, 010 pixel read mask, 011 read-side palette address, 110 index, 111 data. Slots 000, 010, 011 and 110 read back the last value written.
- R3: Select codes 100 and 101 read as 0x00, and writes to them change no register and no palette entry.
- R4: Writing the write-side address resets the byte phase to red. Successive writes to the holding register supply red, then green, then blue. The third write stores {red,green,blue} at the write-side address, which then increments, wrapping from 0xFF to 0x00.
- R5: Writing the read-side address fetches that palette entry and resets the read phase to red. Successive reads of the holding register return red, green and blue. After blue, the read-side address increments (wrapping) and the next entry is fetched.
- R6: A data-register access reaches the extended register selected by the index. Indices 0 to 3 are implemented. Any other index reads as 0x00, and writes to it change nothing.
- R7: One clock after a pixel index is presented, the RGB output (red in [23:16], green in [15:8], blue in [7:0]) equals the palette entry at (index AND read mask).
- R8: In 6-bit mode each output channel is its stored bits [5:0] moved to [7:2], with [1:0] cleared. In 8-bit mode the channel passes unchanged.
- R9: Extended index 0 is the configuration register. While its bit 1 is 0, the synchronized mode input selects the width (high means 8-bit). While bit 1 is 1, configuration bit 0 selects it (1 means 8-bit) and the mode input has no effect.
- R10: A strobe held low for any number of clocks causes exactly one register action, taken after its release.
- R11: Select bit 3 has no effect on register addressing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-side clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd_n | input | 1 | Asynchronous read strobe, active low |
| host_wr_n | input | 1 | Asynchronous write strobe, active low |
| host_sel | input | 4 | Register select; bit 3 is ignored |
| host_din | input | 8 | Write data from host |
| host_dout | output | 8 | Read data of the selected register |
| mode_pin | input | 1 | Dual-function width input (high = 8-bit) |
| pix_idx | input | 8 | Pixel palette index |
| pix_rgb | output | 24 | Masked, width-aligned palette color |

## Verification
The palette path is driven with three pixel-index sweeps: a plain increment, a stride of 37 and a decrement. These are run under an all-ones mask, a low-nibble mask and a zero mask, so that a wrong mask bit or a swapped channel shows up as a mismatch at some index. Palette writes include entries whose low six bits and top two bits differ, so 6-bit alignment can be told apart from pass-through. Each width source is tried in turn: the mode input high and low, then the configuration override with both settings of its width bit. Host traffic includes a write at address 0xFF to expose wrap errors, a burst read across an entry boundary, out-of-range indices, reserved slots, select bit 3 set, and strobes held low for long stretches, which would expose double or early actions.

// File: rtl/pal_host_pkg.sv
package pal_host_pkg;

    localparam int DW        = 8;
    localparam int PAL_DEPTH = 1 << DW;
    localparam int CFG_IDX   = 0;
    localparam int CFG_OVR   = 1;
    localparam int CFG_W8    = 0;

    typedef struct packed {
        logic [DW-1:0] r;
        logic [DW-1:0] g;
        logic [DW-1:0] b;
    } rgb_t;

    typedef enum logic [2:0] {
        SEL_WADDR = 3'd0,
        SEL_HOLD  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_RADDR = 3'd3,
        SEL_RSV0  = 3'd4,
        SEL_RSV1  = 3'd5,
        SEL_INDEX = 3'd6,
        SEL_DATA  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_R = 2'd0,
        PH_G = 2'd1,
        PH_B = 2'd2
    } byte_ph_e;

    function automatic byte_ph_e next_phase(byte_ph_e p);
        case (p)
            PH_R:    return PH_G;
            PH_G:    return PH_B;
            default: return PH_R;
        endcase
    endfunction

    function automatic logic [DW-1:0] widen6(logic [DW-1:0] c);
        return {c[5:0], 2'b00};
    endfunction

    function automatic rgb_t align_rgb(rgb_t c, logic eight);
        rgb_t o;
        if (eight) begin
            o = c;
        end else begin
            o.r = widen6(c.r);
            o.g = widen6(c.g);
            o.b = widen6(c.b);
        end
        return o;
    endfunction

    function automatic logic [DW-1:0] pick_byte(rgb_t c, byte_ph_e p);
        case (p)
            PH_R:    return c.r;
            PH_G:    return c.g;
            default: return c.b;
        endcase
    endfunction

endpackage

// File: rtl/pal_sync.sv
module pal_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pal_color_ram.sv
module pal_color_ram
    import pal_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic [DW-1:0] pf_addr,
    output rgb_t          pf_data,
    input  logic [DW-1:0] px_addr,
    output rgb_t          px_data
);
    rgb_t mem_q [PAL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAL_DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign pf_data = mem_q[pf_addr];
    assign px_data = mem_q[px_addr];
endmodule

// File: rtl/pal_ext_bank.sv
module pal_ext_bank
    import pal_host_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] cfg
);
    logic [N_EXT-1:0][DW-1:0] regs_q;
    logic [N_EXT-1:0]         hit;

    for (genvar k = 0; k < N_EXT; k++) begin : g_reg
        assign hit[k] = (idx == DW'(k));
        always_ff @(posedge clk) begin
            if (rst)               regs_q[k] <= '0;
            else if (we && hit[k]) regs_q[k] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_EXT; k++)
            if (hit[k]) rdata = regs_q[k];
    end

    assign cfg = regs_q[CFG_IDX];

    p_unimpl_write_r6: assert property (@(posedge clk) disable iff (rst)
        (we && hit == '0) |=> $stable(regs_q));
    p_single_hit_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
endmodule

// File: rtl/pal_host_if.sv
module pal_host_if
    import pal_host_pkg::*;
#(
    parameter int N_EXT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [3:0]    host_sel,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    input  logic          mode_pin,
    input  logic [DW-1:0] pix_idx,
    output logic [23:0]   pix_rgb
);
    // strobe synchronization and trailing-edge detection
    logic rd_lvl, wr_lvl, pin_lvl, rd_d, wr_d, rd_ev, wr_ev;

    pal_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync
        (.clk(clk), .rst(rst), .async_in(host_rd_n), .sync_out(rd_lvl));
    pal_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync
        (.clk(clk), .rst(rst), .async_in(host_wr_n), .sync_out(wr_lvl));
    pal_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync
        (.clk(clk), .rst(rst), .async_in(mode_pin), .sync_out(pin_lvl));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_d <= 1'b1;
            wr_d <= 1'b1;
        end else begin
            rd_d <= rd_lvl;
            wr_d <= wr_lvl;
        end
    end

    assign rd_ev = rd_lvl & ~rd_d;
    assign wr_ev = wr_lvl & ~wr_d;

    // select decode; bit 3 plays no part in addressing
    reg_sel_e sel;
    logic     unused_sel3;
    assign sel         = reg_sel_e'(host_sel[2:0]);
    assign unused_sel3 = host_sel[3];

    // direct registers
    logic [DW-1:0] waddr_q, raddr_q, mask_q, index_q;
    byte_ph_e      wph_q, rph_q;
    logic [DW-1:0] hold_r_q, hold_g_q;
    rgb_t          latch_q;

    logic          ram_we;
    rgb_t          ram_wdata, pf_data, px_data;
    logic [DW-1:0] pf_addr, ext_rdata, cfg;
    logic          ext_we;
    logic          raddr_load, rd_hold;

    assign raddr_load = wr_ev && (sel == SEL_RADDR);
    assign rd_hold    = rd_ev && !wr_ev && (sel == SEL_HOLD);
    assign ram_we     = wr_ev && (sel == SEL_HOLD) && (wph_q == PH_B);
    assign ram_wdata  = '{r: hold_r_q, g: hold_g_q, b: host_din};
    assign pf_addr    = raddr_load ? host_din : raddr_q + 1'b1;
    assign ext_we     = wr_ev && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr_q  <= '0;
            raddr_q  <= '0;
            mask_q   <= '1;
            index_q  <= '0;
            wph_q    <= PH_R;
            rph_q    <= PH_R;
            hold_r_q <= '0;
            hold_g_q <= '0;
            latch_q  <= '0;
        end else if (wr_ev) begin
            case (sel)
                SEL_WADDR: begin
                    waddr_q <= host_din;
                    wph_q   <= PH_R;
                end
                SEL_HOLD: begin
                    case (wph_q)
                        PH_R:    hold_r_q <= host_din;
                        PH_G:    hold_g_q <= host_din;
                        default: waddr_q  <= waddr_q + 1'b1;
                    endcase
                    wph_q <= next_phase(wph_q);
                end
                SEL_MASK:  mask_q  <= host_din;
                SEL_RADDR: begin
                    raddr_q <= host_din;
                    latch_q <= pf_data;
                    rph_q   <= PH_R;
                end
                SEL_INDEX: index_q <= host_din;
                default: ;
            endcase
        end else if (rd_hold) begin
            if (rph_q == PH_B) begin
                raddr_q <= raddr_q + 1'b1;
                latch_q <= pf_data;
            end
            rph_q <= next_phase(rph_q);
        end
    end

    pal_color_ram u_ram (
        .clk(clk), .rst(rst),
        .we(ram_we), .waddr(waddr_q), .wdata(ram_wdata),
        .pf_addr(pf_addr), .pf_data(pf_data),
        .px_addr(pix_idx & mask_q), .px_data(px_data)
    );

    pal_ext_bank #(.N_EXT(N_EXT)) u_ext (
        .clk(clk), .rst(rst),
        .we(ext_we), .idx(index_q), .wdata(host_din),
        .rdata(ext_rdata), .cfg(cfg)
    );

    // host read mux
    always_comb begin
        case (sel)
            SEL_WADDR: host_dout = waddr_q;
            SEL_HOLD:  host_dout = pick_byte(latch_q, rph_q);
            SEL_MASK:  host_dout = mask_q;
            SEL_RADDR: host_dout = raddr_q;
            SEL_INDEX: host_dout = index_q;
            SEL_DATA:  host_dout = ext_rdata;
            default:   host_dout = '0;
        endcase
    end

    // pixel path
    rgb_t pix_q;
    logic eight_bit;

    always_ff @(posedge clk) begin
        if (rst) pix_q <= '0;
        else     pix_q <= px_data;
    end

    assign eight_bit = cfg[CFG_OVR] ? cfg[CFG_W8] : pin_lvl;
    assign pix_rgb   = align_rgb(pix_q, eight_bit);

    // assertions
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_ev && sel == SEL_MASK) |=> $stable(mask_q));
    p_reserved_noop_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ev && host_sel[2:1] == 2'b10)
        |=> ($stable(waddr_q) && $stable(raddr_q) && $stable(mask_q) && $stable(index_q)));
    p_waddr_step_r4: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (waddr_q == $past(waddr_q) + 8'd1));
    p_wph_legal_r4: assert property (@(posedge clk) disable iff (rst)
        wph_q != 2'd3);
    p_raddr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && rph_q == PH_B) |=> (raddr_q == $past(raddr_q) + 8'd1 && rph_q == PH_R));
    p_one_rd_event_r10: assert property (@(posedge clk) disable iff (rst)
        rd_ev |=> !rd_ev);
    p_one_wr_event_r10: assert property (@(posedge clk) disable iff (rst)
        wr_ev |=> !wr_ev);
    p_pin_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg[CFG_OVR] && $stable(cfg)) |-> $stable(eight_bit));
endmodule

// File: tb/sim_pal_host_if.sv
module sim_pal_host_if;
    localparam int CLK_PERIOD = 10;
    localparam int NEXT       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [3:0]  host_sel = '0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        mode_pin = 1'b1;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int errors = 0;
    int checks = 0;
    bit quiet  = 1'b0;
    bit done   = 1'b0;
    int step   = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_host_if u0 (
        .clk(clk), .rst(rst), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_sel(host_sel), .host_din(host_din), .host_dout(host_dout),
        .mode_pin(mode_pin), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    // behavioural reference state
    int m_ram [256];
    int m_mask, m_waddr, m_raddr, m_wcnt, m_rcnt, m_index;
    int m_hr, m_hg, m_latch;
    int m_ext [NEXT];
    int m_pin;

    task automatic m_reset();
        foreach (m_ram[i]) m_ram[i] = 0;
        foreach (m_ext[i]) m_ext[i] = 0;
        m_mask = 255; m_waddr = 0; m_raddr = 0; m_wcnt = 0; m_rcnt = 0;
        m_index = 0; m_hr = 0; m_hg = 0; m_latch = 0;
    endtask

    function automatic int m_peek(int s);
        case (s % 8)
            0: return m_waddr;
            1: return (m_latch >> (16 - 8*m_rcnt)) & 255;
            2: return m_mask;
            3: return m_raddr;
            6: return m_index;
            7: return (m_index < NEXT) ? m_ext[m_index] : 0;
            default: return 0;
        endcase
    endfunction

    task automatic m_read_side(int s);
        if (s % 8 == 1) begin
            if (m_rcnt == 2) begin
                m_raddr = (m_raddr + 1) % 256;
                m_latch = m_ram[m_raddr];
                m_rcnt = 0;
            end else m_rcnt++;
        end
    endtask

    task automatic m_write(int s, int d);
        case (s % 8)
            0: begin m_waddr = d; m_wcnt = 0; end
            1: begin
                if (m_wcnt == 0) m_hr = d;
                else if (m_wcnt == 1) m_hg = d;
                else begin
                    m_ram[m_waddr] = (m_hr << 16) | (m_hg << 8) | d;
                    m_waddr = (m_waddr + 1) % 256;
                end
                m_wcnt = (m_wcnt + 1) % 3;
            end
            2: m_mask = d;
            3: begin m_raddr = d; m_latch = m_ram[d]; m_rcnt = 0; end
            6: m_index = d;
            7: if (m_index < NEXT) m_ext[m_index] = d;
            default: ;
        endcase
    endtask

    function automatic int m_pixel(int idx);
        int c, o;
        bit eight;
        c = m_ram[idx & m_mask];
        eight = m_ext[0][1] ? m_ext[0][0] : m_pin[0];
        if (eight) return c;
        o = 0;
        for (int k = 0; k < 3; k++)
            o |= (((c >> (8*k)) & 63) << 2) << (8*k);
        return o;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pixel comparison on every clock while the host side is idle (R7, R8, R9)
    int idx_cap = 0;
    always @(posedge clk) idx_cap <= int'(pix_idx);
    always @(negedge clk) begin
        if (quiet && !rst) check("R7 pixel", int'(pix_rgb), m_pixel(idx_cap));
        if (!rst) pix_idx <= pix_idx + 8'(step);
    end

    task automatic hw(int s, int d, int hold = 4);
        quiet = 1'b0;
        @(negedge clk);
        host_sel = 4'(s); host_din = 8'(d); host_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        m_write(s, d);
        @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic hr(int s, string tag, int hold = 4);
        quiet = 1'b0;
        @(negedge clk);
        host_sel = 4'(s); host_rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        check(tag, int'(host_dout), m_peek(s));
        host_rd_n = 1'b1;
        repeat (6) @(negedge clk);
        m_read_side(s);
        @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic set_pin(int v);
        quiet = 1'b0;
        mode_pin = v[0];
        m_pin = v;
        repeat (5) @(negedge clk);
        quiet = 1'b1;
    endtask

    task automatic put_rgb(int c);
        hw(1, (c >> 16) & 255);
        hw(1, (c >> 8) & 255);
        hw(1, c & 255);
    endtask

    initial begin
        m_reset();
        m_pin = 1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        quiet = 1'b1;
        repeat (8) @(negedge clk);

        // R1 reset values
        hr(2, "R1 mask reset");
        hr(0, "R1 waddr reset");
        hr(3, "R1 raddr reset");
        hr(6, "R1 index reset");
        hr(7, "R1 config reset");

        // R2, R4 palette fill including wrap at 0xFF
        hw(0, 8'h10);
        hr(0, "R2 waddr readback");
        put_rgb(24'hC3_5A_81);
        put_rgb(24'h3F_FF_40);
        put_rgb(24'h81_02_FE);
        hr(0, "R4 waddr increment");
        hw(0, 8'hFF);
        put_rgb(24'h12_E4_7B);
        put_rgb(24'hAA_55_CC);
        hr(0, "R4 waddr wrap");
        hw(0, 8'h20);
        hw(1, 8'h99);
        hw(0, 8'h21);
        put_rgb(24'h01_23_45);
        hr(0, "R4 phase reset by address write");
        for (int i = 0; i < 12; i++) begin
            hw(0, 8'h30 + i*7);
            put_rgb((i * 24'h1F_3B_57 + 24'h0F_C2_A9) & 24'hFFFFFF);
        end

        // R5 read path across an entry boundary and the wrap
        hw(3, 8'h10);
        for (int i = 0; i < 9; i++) hr(1, "R5 palette read");
        hr(3, "R5 raddr advanced");
        hw(3, 8'hFF);
        for (int i = 0; i < 6; i++) hr(1, "R5 read wrap");
        hr(3, "R5 raddr wrap");

        // R7 sweeps under three masks
        step = 1;  repeat (300) @(negedge clk);
        step = 37; repeat (300) @(negedge clk);
        hw(2, 8'h0F);
        hr(2, "R2 mask readback");
        step = 255; repeat (100) @(negedge clk);
        hw(2, 8'h00);
        repeat (50) @(negedge clk);
        hw(2, 8'hFF);

        // R8, R9 width sources
        set_pin(0); step = 3;  repeat (200) @(negedge clk);
        set_pin(1); repeat (100) @(negedge clk);
        hw(6, 0);
        hw(7, 8'h02);
        hr(7, "R9 config readback");
        repeat (100) @(negedge clk);
        set_pin(0); repeat (50) @(negedge clk);
        hw(7, 8'h03);
        repeat (100) @(negedge clk);
        set_pin(1); repeat (50) @(negedge clk);
        hw(7, 8'h00);
        repeat (50) @(negedge clk);

        // R6 extended bank
        hw(6, 2); hw(7, 8'h5C); hr(7, "R6 ext write/read");
        hw(6, 3); hw(7, 8'hA7); hr(7, "R6 ext write/read");
        hw(6, 8'h40); hw(7, 8'hEE); hr(7, "R6 unimplemented reads zero");
        hw(6, 4); hw(7, 8'h11); hr(7, "R6 unimplemented reads zero");
        hw(6, 2); hr(7, "R6 untouched by unimplemented write");
        hw(6, 0); hr(7, "R6 config untouched");
        repeat (20) @(negedge clk);

        // R3 reserved slots
        hw(4, 8'h77); hw(5, 8'h33);
        hr(4, "R3 reserved reads zero");
        hr(5, "R3 reserved reads zero");
        hr(0, "R3 waddr unchanged"); hr(2, "R3 mask unchanged");
        hr(3, "R3 raddr unchanged"); hr(6, "R3 index unchanged");
        repeat (300) @(negedge clk);

        // R11 select bit 3 ignored
        hw(8 + 2, 8'h3C);
        hr(2, "R11 mask via sel bit3");
        hr(8 + 2, "R11 read with sel bit3");
        hw(8 + 6, 3); hr(8 + 7, "R11 data via sel bit3");
        hw(2, 8'hFF);

        // R10 long strobes act once, after release
        hw(0, 8'h50);
        hw(1, 8'h6D, 40);
        hw(1, 8'h92, 25);
        hw(1, 8'h0B, 60);
        hr(0, "R10 single step after long writes");
        hw(3, 8'h50);
        hr(1, "R10 long read", 50);
        hr(1, "R10 long read", 30);
        hr(1, "R10 long read", 45);
        hr(3, "R10 single advance");
        step = 1; repeat (300) @(negedge clk);

        done = 1'b1;
    end

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < 150000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        quiet = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule